// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block sequences the drive pattern for a liquid-crystal panel with 24 segment lines and up to four backplane lines. A free-running counter chain, clocked by the core clock, divides each frame into one multiplex slot per active backplane and splits every slot into two equal halves. For each slot the block picks one bit column of an external 24 x 4 display memory and turns the 24 bits of that column into segment drive codes. Each backplane and each segment output carries a 2-bit level code. The analog stage that follows maps the code to a voltage: 00 is the top rail, 01 the upper inner level, 10 the lower inner level and 11 the bottom rail.

Software settings choose the drive mode, the bias, the power-saving frame rate, the displayed memory bank and the blink behaviour. The settings arrive as static inputs. Several drivers can share one wired synchronisation line: each driver pulls the line during its last slot and realigns when another driver pulls it first.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: While reset is held and just after it, the sequencer sits at slot 0, first half, showing column 0 with blinking in its on phase. With 4-backplane mode selected, the backplane word is 8'hA8 and the sync line is not driven.
- R2: drive_mode encodes 0 = static (1 slot), 1 = 2-way, 2 = 3-way and 3 = 4-way multiplex. One frame lasts 2880 core clocks, or 480 when pwr_save is 1. Each of the N slots lasts frame/N clocks and is split into two halves of frame/(2N) clocks.
- R3: In 4-way mode the slots show memory columns 0, 1, 2, 3 in that order. In 3-way mode they show 0, 1, 2. In 2-way mode they show 0, 1. In static mode they show column 0 only. col_sel carries the column number.
- R4: With out_bank = 1, static mode shows column 2 and 2-way mode shows columns 2 and 3. out_bank has no effect in 3-way or 4-way mode.
- R5: Backplane i is bp_lvl[2i+1:2i]. In static mode all four backplanes carry the same code. In 2-way mode backplane 2 copies backplane 0 and backplane 3 copies backplane 1. In 3-way mode backplane 3 copies backplane 1.
- R6: With third bias (3-way, 4-way, or 2-way with bias_third = 1), the first half of a slot drives the selected backplane to 00 and every unselected backplane to 10. An on segment is driven to 11 and an off segment to 01.
- R7: Rail style applies in static mode and in 2-way mode with bias_third = 0. In rail style an on segment is 11 and an off segment is 00 in the first half. Unselected backplanes hold 01 in both halves.
- R8: The second half of every slot inverts both bits of every code, except the 01 mid level of rail style, which stays 01.
- R9: With disp_en = 0, every segment is driven to the off level of the current mode and half.
- R10: blink_rate selects the blink period: 1 gives 92160 clocks, 2 gives 184320 and 3 gives 368640. In power-saving mode the periods are 15360, 30720 and 61440. The first half of each period is the on phase and the second half the off phase. Rate 0 disables blinking. With blink_alt = 0, all segments are off during the off phase.
- R11: With blink_alt = 1 in static or 2-way mode, the off phase swaps the shown bank (column + 2 becomes column, and column becomes column + 2) instead of blanking. In 3-way and 4-way modes, blink_alt = 1 blanks the display as in R10.
- R12: sync_drive is 1 during the first half of the last active slot and 0 at all other times.
- R13: sync_in = 1 sampled while the sequencer is outside its last slot moves it, on the next clock, to the start of the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_mode | input | 2 | 0 static, 1/2/3 for 2/3/4-way multiplex |
| bias_third | input | 1 | 2-way mode: 1 selects third bias, 0 selects half bias |
| disp_en | input | 1 | Display enable; 0 turns all segments off |
| pwr_save | input | 1 | Selects the shorter frame and blink periods |
| out_bank | input | 1 | Shows the alternate bank in static and 2-way modes |
| blink_rate | input | 2 | 0 off, 1/2/3 select the blink period |
| blink_alt | input | 1 | Blink by swapping banks instead of blanking |
| col_sel | output | 2 | Memory bit column being read |
| col_data | input | 24 | The selected column, one bit per segment |
| sync_in | input | 1 | Wired sync line seen as asserted |
| sync_drive | output | 1 | Request to pull the wired sync line |
| bp_lvl | output | 8 | Four backplane level codes |
| seg_lvl | output | 48 | 24 segment level codes |

## Verification
The assertions assume that drive_mode stays constant between resets. They also assume that col_data depends only on col_sel during a slot, and that an external sync pulse arrives outside the sequencer's own drive window. The stimulus sets every configuration input while reset is held and changes none of them until the next reset. It models the memory as a fixed combinational table indexed by col_sel. It raises sync_in for a single clock, early in the first slot.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'd0,
        MODE_MUX2   = 2'd1,
        MODE_MUX3   = 2'd2,
        MODE_MUX4   = 2'd3
    } drive_mode_e;

    localparam logic [1:0] LVL_TOP = 2'b00;
    localparam logic [1:0] LVL_UP  = 2'b01;
    localparam logic [1:0] LVL_LOW = 2'b10;
    localparam logic [1:0] LVL_BOT = 2'b11;

    // Backplane code: selected -> top rail, unselected -> inner level.
    // The rail-style mid level is not inverted.
    function automatic logic [1:0] bp_code(input logic sel, input logic rail, input logic inv);
        logic [1:0] c;
        if (!sel && rail) begin
            bp_code = LVL_UP;
        end else begin
            c = sel ? LVL_TOP : LVL_LOW;
            bp_code = inv ? ~c : c;
        end
    endfunction

    function automatic logic [1:0] seg_code(input logic on, input logic rail, input logic inv);
        logic [1:0] c;
        c = on ? LVL_BOT : (rail ? LVL_TOP : LVL_UP);
        seg_code = inv ? ~c : c;
    endfunction

endpackage

// File: rtl/lcdseq_timebase.sv
module lcdseq_timebase
    import lcdseq_pkg::*;
#(
    parameter int unsigned FRAME_NORM = 2880,
    parameter int unsigned FRAME_SAVE = 480
) (
    input  logic        clk,
    input  logic        rst_n,
    input  drive_mode_e mode,
    input  logic        pwr_save,
    input  logic        sync_in,
    output logic [1:0]  slot,
    output logic        half,
    output logic        sync_drive
);
    localparam int unsigned CW = $clog2(FRAME_NORM / 2 + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          half;
        logic [1:0]    slot;
    } tb_state_t;

    tb_state_t     st_d, st_q;
    logic [CW-1:0] half_len;
    logic [1:0]    last_slot;
    logic          resync;

    always_comb begin
        case ({pwr_save, mode})
            3'b000:  half_len = CW'(FRAME_NORM / 2);
            3'b001:  half_len = CW'(FRAME_NORM / 4);
            3'b010:  half_len = CW'(FRAME_NORM / 6);
            3'b011:  half_len = CW'(FRAME_NORM / 8);
            3'b100:  half_len = CW'(FRAME_SAVE / 2);
            3'b101:  half_len = CW'(FRAME_SAVE / 4);
            3'b110:  half_len = CW'(FRAME_SAVE / 6);
            default: half_len = CW'(FRAME_SAVE / 8);
        endcase
    end

    assign last_slot  = mode;
    assign resync     = sync_in && (st_q.slot != last_slot);
    assign sync_drive = (st_q.slot == last_slot) && !st_q.half;
    assign slot       = st_q.slot;
    assign half       = st_q.half;

    always_comb begin
        st_d = st_q;
        if (resync) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
            st_d.slot = last_slot;
        end else if (st_q.cnt >= half_len - 1'b1) begin
            st_d.cnt  = '0;
            st_d.half = !st_q.half;
            if (st_q.half) begin
                st_d.slot = (st_q.slot >= last_slot) ? 2'd0 : st_q.slot + 2'd1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_slot_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(resync) && st_q.slot != $past(st_q.slot))
            |-> (st_q.slot == 2'd0 || st_q.slot == $past(st_q.slot) + 2'd1));

    assert_half_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(resync) && st_q.half != $past(st_q.half))
            |-> ($past(st_q.cnt) >= $past(half_len) - 1'b1));

    assert_sync_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sync_drive |=> (sync_drive || st_q.half || !$stable(mode)));

endmodule

// File: rtl/lcdseq_blink.sv
module lcdseq_blink #(
    parameter int unsigned BLINK_NORM = 92160,
    parameter int unsigned BLINK_SAVE = 15360
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate,
    input  logic       pwr_save,
    output logic       off_phase
);
    localparam int unsigned BW = $clog2(BLINK_NORM * 2);

    typedef struct packed {
        logic [BW-1:0] cnt;
        logic          phase;
    } bl_state_t;

    bl_state_t     st_d, st_q;
    logic [BW-1:0] base, half_per;

    assign base = pwr_save ? BW'(BLINK_SAVE / 2) : BW'(BLINK_NORM / 2);

    always_comb begin
        case (rate)
            2'd2:    half_per = base << 1;
            2'd3:    half_per = base << 2;
            default: half_per = base;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rate == 2'd0) begin
            st_d.cnt   = '0;
            st_d.phase = 1'b0;
        end else if (st_q.cnt >= half_per - 1'b1) begin
            st_d.cnt   = '0;
            st_d.phase = !st_q.phase;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign off_phase = st_q.phase;

    assert_phase_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != $past(st_q.phase) && $past(rate) != 2'd0) |-> (st_q.cnt == '0));

    assert_idle_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == 2'd0) |=> !off_phase);

endmodule

// File: rtl/lcdseq_levels.sv
module lcdseq_levels
    import lcdseq_pkg::*;
#(
    parameter int unsigned NSEG = 24
) (
    input  drive_mode_e       mode,
    input  logic              bias_third,
    input  logic              half,
    input  logic [1:0]        slot,
    input  logic [NSEG-1:0]   seg_on,
    output logic [7:0]        bp_lvl,
    output logic [2*NSEG-1:0] seg_lvl
);
    logic rail;

    assign rail = (mode == MODE_STATIC) || (mode == MODE_MUX2 && !bias_third);

    for (genvar b = 0; b < 4; b++) begin : g_bp
        localparam logic [1:0] BI = 2'(b);
        logic [1:0] src;
        always_comb begin
            case (mode)
                MODE_STATIC: src = 2'd0;
                MODE_MUX2:   src = {1'b0, BI[0]};
                MODE_MUX3:   src = (BI == 2'd3) ? 2'd1 : BI;
                default:     src = BI;
            endcase
        end
        assign bp_lvl[2*b +: 2] = bp_code(src == slot, rail, half);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign seg_lvl[2*s +: 2] = seg_code(seg_on[s], rail, half);
    end

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
    import lcdseq_pkg::*;
#(
    parameter int unsigned NSEG       = 24,
    parameter int unsigned FRAME_NORM = 2880,
    parameter int unsigned FRAME_SAVE = 480,
    parameter int unsigned BLINK_NORM = 92160,
    parameter int unsigned BLINK_SAVE = 15360
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        drive_mode,
    input  logic              bias_third,
    input  logic              disp_en,
    input  logic              pwr_save,
    input  logic              out_bank,
    input  logic [1:0]        blink_rate,
    input  logic              blink_alt,
    output logic [1:0]        col_sel,
    input  logic [NSEG-1:0]   col_data,
    input  logic              sync_in,
    output logic              sync_drive,
    output logic [7:0]        bp_lvl,
    output logic [2*NSEG-1:0] seg_lvl
);
    drive_mode_e     mode;
    logic [1:0]      slot;
    logic            half;
    logic            off_phase;
    logic            banked_mode;
    logic            bank_eff;
    logic            blank;
    logic [NSEG-1:0] seg_on;
    logic [3:0]      bp_top;

    assign mode = drive_mode_e'(drive_mode);

    lcdseq_timebase #(
        .FRAME_NORM (FRAME_NORM),
        .FRAME_SAVE (FRAME_SAVE)
    ) i_timebase (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .pwr_save   (pwr_save),
        .sync_in    (sync_in),
        .slot       (slot),
        .half       (half),
        .sync_drive (sync_drive)
    );

    lcdseq_blink #(
        .BLINK_NORM (BLINK_NORM),
        .BLINK_SAVE (BLINK_SAVE)
    ) i_blink (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate      (blink_rate),
        .pwr_save  (pwr_save),
        .off_phase (off_phase)
    );

    assign banked_mode = (mode == MODE_STATIC) || (mode == MODE_MUX2);
    assign bank_eff    = banked_mode && (out_bank ^ (blink_alt && off_phase));
    assign col_sel     = slot | {bank_eff, 1'b0};
    assign blank       = !disp_en || (off_phase && !(blink_alt && banked_mode));
    assign seg_on      = blank ? '0 : col_data;

    lcdseq_levels #(
        .NSEG (NSEG)
    ) i_levels (
        .mode       (mode),
        .bias_third (bias_third),
        .half       (half),
        .slot       (slot),
        .seg_on     (seg_on),
        .bp_lvl     (bp_lvl),
        .seg_lvl    (seg_lvl)
    );

    for (genvar b = 0; b < 4; b++) begin : g_top
        assign bp_top[b] = (bp_lvl[2*b +: 2] == LVL_TOP);
    end

    assert_disabled_uniform_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (seg_lvl == {NSEG{seg_lvl[1:0]}}));

    assert_static_bp_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STATIC) |-> (bp_lvl == {4{bp_lvl[1:0]}}));

    assert_one_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MUX4 && !half) |-> ($countones(bp_top) == 1));

endmodule

// File: tb/test_lcd_mux_sequencer.sv
`timescale 1ns/1ps
module test_lcd_mux_sequencer;

    typedef struct packed {
        logic [1:0]  mode;
        logic        ps;
        logic        bias;
        logic        bank;
        logic        en;
        logic [1:0]  rate;
        logic        alt;
        logic [3:0]  req;
        logic [31:0] t;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd3,  32'd130},   // R3 slot 1
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd6,  32'd250},   // R6 slot 2
        '{2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 4'd4,  32'd370},   // R4 bank ignored, R12 drive
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd12, 32'd359},   // R12 not yet
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 4'd4,  32'd90},    // R4 3-way ignores bank
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd5,  32'd330},   // R5 3-way mirror
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd5,  32'd130},   // R5 2-way mirror
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd7,  32'd250},   // R7 half bias
        '{2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 4'd4,  32'd370},   // R4 2-way bank
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd7,  32'd100},   // R7 static
        '{2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 4'd8,  32'd300},   // R8 inverted half
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd2,  32'd1500},  // R2 normal frame
        '{2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd2,  32'd1100},  // R2 normal 4-way
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd9,  32'd70},    // R9 disabled
        '{2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 4'd10, 32'd7700},  // R10 blanked
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 4'd11, 32'd7700},  // R11 bank swap
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 4'd11, 32'd7700},  // R11 4-way blank
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 4'd10, 32'd7700},  // R10 slower rate on
        '{2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 4'd10, 32'd15400}, // R10 back on
        '{2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 4'd3,  32'd70}     // R3 slot 0 half 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  drive_mode = 2'd3;
    logic        bias_third = 1'b1, disp_en = 1'b1, pwr_save = 1'b1, out_bank = 1'b0;
    logic [1:0]  blink_rate = 2'd0;
    logic        blink_alt = 1'b0, sync_in = 1'b0;
    logic [1:0]  col_sel;
    logic [23:0] col_data;
    logic        sync_drive;
    logic [7:0]  bp_lvl;
    logic [47:0] seg_lvl;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    function automatic logic [23:0] mem_col(input logic [1:0] c);
        case (c)
            2'd0:    return 24'h5A3C96;
            2'd1:    return 24'hC30FF1;
            2'd2:    return 24'h0F7E21;
            default: return 24'hB4D28E;
        endcase
    endfunction

    always_comb col_data = mem_col(col_sel);

    lcd_mux_sequencer i_lcd_mux_sequencer (
        .clk(clk), .rst_n(rst_n), .drive_mode(drive_mode), .bias_third(bias_third),
        .disp_en(disp_en), .pwr_save(pwr_save), .out_bank(out_bank),
        .blink_rate(blink_rate), .blink_alt(blink_alt), .col_sel(col_sel),
        .col_data(col_data), .sync_in(sync_in), .sync_drive(sync_drive),
        .bp_lvl(bp_lvl), .seg_lvl(seg_lvl)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start(input vec_t v);
        rst_n = 1'b0;
        drive_mode = v.mode; pwr_save = v.ps; bias_third = v.bias; out_bank = v.bank;
        disp_en = v.en; blink_rate = v.rate; blink_alt = v.alt; sync_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic run_vec(input vec_t v);
        int n, h, k, sl, hpb;
        logic hf, off, low, bank, blank, rail, sel, on;
        logic [1:0] col, src, c;
        logic [7:0] ebp;
        logic [47:0] eseg;
        logic [23:0] d;
        string tag;
        start(v);
        repeat (v.t) @(posedge clk);
        @(negedge clk);
        n = int'(v.mode) + 1;
        h = (v.ps ? 480 : 2880) / (2 * n);
        k = int'(v.t) / h;
        hf = k[0];
        sl = (k / 2) % n;
        off = 1'b0;
        if (v.rate != 2'd0) begin
            hpb = (v.ps ? 7680 : 46080) << (int'(v.rate) - 1);
            off = ((int'(v.t) / hpb) % 2) == 1;
        end
        low = (v.mode <= 2'd1);
        bank = low && (v.bank ^ (v.alt && off));
        col = 2'(sl) + (bank ? 2'd2 : 2'd0);
        blank = !v.en || (off && !(v.alt && low));
        rail = (v.mode == 2'd0) || (v.mode == 2'd1 && !v.bias);
        for (int b = 0; b < 4; b++) begin
            case (v.mode)
                2'd0: src = 2'd0;
                2'd1: src = 2'(b % 2);
                2'd2: src = (b == 3) ? 2'd1 : 2'(b);
                default: src = 2'(b);
            endcase
            sel = (int'(src) == sl);
            if (!sel && rail) c = 2'b01;
            else begin c = sel ? 2'b00 : 2'b10; if (hf) c = ~c; end
            ebp[2*b +: 2] = c;
        end
        d = mem_col(col);
        for (int s = 0; s < 24; s++) begin
            on = !blank && d[s];
            c = on ? 2'b11 : (rail ? 2'b00 : 2'b01);
            if (hf) c = ~c;
            eseg[2*s +: 2] = c;
        end
        tag = $sformatf("R%0d t=%0d mode=%0d", v.req, v.t, v.mode);
        check({tag, " col_sel"},    64'(col_sel),    64'(col));
        check({tag, " bp_lvl"},     64'(bp_lvl),     64'(ebp));
        check({tag, " seg_lvl"},    64'(seg_lvl),    64'(eseg));
        check({tag, " sync_drive"}, 64'(sync_drive), 64'((sl == n - 1) && !hf));
    endtask

    initial begin
        vec_t v;
        // R1: state while reset is held, 4-way mode
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 col_sel in reset",    64'(col_sel),    64'd0);
        check("R1 sync_drive in reset", 64'(sync_drive), 64'd0);
        check("R1 bp_lvl in reset",     64'(bp_lvl),     64'h A8);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R13: external sync pulse early in the frame
        v = VECS[0];
        start(v);
        repeat (10) @(posedge clk);
        @(negedge clk) sync_in = 1'b1;
        @(posedge clk);
        @(negedge clk) sync_in = 1'b0;
        check("R13 col_sel after resync",    64'(col_sel),    64'd3);
        check("R13 sync_drive after resync", 64'(sync_drive), 64'd1);
        check("R13 bp3 selected",            64'(bp_lvl),     64'h2A);
        repeat (120) @(posedge clk);
        @(negedge clk);
        check("R13 wrapped to slot 0",       64'(col_sel),    64'd0);
        check("R13 sync released",           64'(sync_drive), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule